// File: doc/BRIEF.md
# Group-Selectable Parallel-Access Bit Array

A single-bit storage array organised as `NUM_WORDS` word lines crossed by `NUM_BITS` bit lines. In normal mode it behaves like an ordinary 1-bit-wide memory: a bit-line address and a word-line address pick one cell for a read or a write. In test mode the word-line address still picks exactly one word line, but the bit-line decoder opens every bit line whose index, taken modulo `NUM_GROUPS`, equals the group select. A single write then fills the whole group on that word line with the data bit, and a single read checks the whole group at once.

On a test-mode read the selected cells go to an all-equal comparator. One cycle later a registered error flag reports whether they disagree. The comparator accepts both all-zero and all-one contents, so a group that flipped as a whole is not flagged. For that reason the data-out bit also carries the value of the lowest-index selected cell, and a tester compares it against the expected polarity. The error flag is driven by a three-state machine. CLAMPED is entered on reset, on any write and on any normal-mode cycle. A test-mode read moves it to PASS when the group agrees and to FAIL when it does not. Test-mode idle cycles keep the current state. The flag is high only in FAIL.

Top module: `pam_array_top`

## Requirements
- R1: After reset every cell holds 0, `dout` is 0 and `err` is 0.
- R2: In normal mode (`test_mode`=0) a cycle with `wr_en`=1 stores `din` into the single cell at (`bit_addr`, `word_addr`) and leaves every other cell unchanged.
- R3: In normal mode a cycle with `rd_en`=1 and `wr_en`=0 makes `dout` equal the addressed cell from the next cycle on; `dout` keeps its value in every cycle that performs no read.
- R4: Bit line i belongs to group i mod `NUM_GROUPS`; in test mode a write stores `din` into every cell of group `grp_sel` on word line `word_addr` and leaves cells of other groups and other word lines unchanged.
- R5: In test mode a read sets `dout`, one cycle later, to the cell on bit line index `grp_sel` (the lowest-index member of the group) of the selected word line.
- R6: In test mode a read sets `err`, one cycle later, to 1 when the selected cells are not all equal and to 0 when they are all 0 or all 1.
- R7: In test mode `err` keeps its value through cycles with neither `rd_en` nor `wr_en`.
- R8: Any cycle with `wr_en`=1 forces `err` to 0 in the next cycle; a read strobed in the same cycle as a write is ignored and `dout` holds.
- R9: Any cycle with `test_mode`=0 forces `err` to 0 in the next cycle.
- R10: A group read in test mode whose cells are all 1 and one whose cells are all 0 both give `err`=0; the two cases differ only in `dout` (1 versus 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_mode | input | 1 | 1 selects group access, 0 selects single-cell access |
| grp_sel | input | $clog2(NUM_GROUPS) | Group index used in test mode |
| word_addr | input | $clog2(NUM_WORDS) | Word-line address, both modes |
| bit_addr | input | $clog2(NUM_BITS) | Bit-line address, normal mode only |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe, wins over a simultaneous read |
| din | input | 1 | Data bit to write |
| dout | output | 1 | Registered read data |
| err | output | 1 | Registered group-mismatch flag |

## Verification
A corrupted cell shows up at the ports only when it is read: a normal read puts the wrong bit on `dout` one cycle later, and a test-mode read of its group raises `err` one cycle later unless the whole group is wrong together, in which case only `dout` shows it. A wrong error-machine state is visible directly on `err` in the cycle after the transition that caused it, for example a flag that survives a write or a normal-mode cycle. A decoder that opens the wrong bit lines leaves the damage latent until a later read of a neighbouring group or word line, so the bench mirrors the full array and reads back cells outside the targeted group after group writes.

// File: rtl/pam_pkg.sv
package pam_pkg;

    // State of the mismatch flag controller
    typedef enum logic [1:0] {
        ERR_CLAMPED = 2'd0,
        ERR_PASS    = 2'd1,
        ERR_FAIL    = 2'd2
    } err_state_e;

    // Kind of access presented in the current cycle
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } access_e;

endpackage

// File: rtl/pam_bit_decoder.sv
module pam_bit_decoder #(
    parameter int NUM_BITS   = 8,
    parameter int NUM_GROUPS = 2,
    localparam int BAW = $clog2(NUM_BITS),
    localparam int GW  = $clog2(NUM_GROUPS)
) (
    input  logic                test_mode,
    input  logic [GW-1:0]       grp_sel,
    input  logic [BAW-1:0]      bit_addr,
    output logic [NUM_BITS-1:0] sel_mask
);

    // One select line per bit line; group membership is fixed at elaboration
    for (genvar i = 0; i < NUM_BITS; i++) begin : g_line
        localparam int LINE_GRP = i % NUM_GROUPS;
        logic hit_group;
        logic hit_single;
        assign hit_group  = (grp_sel == GW'(LINE_GRP));
        assign hit_single = (bit_addr == BAW'(i));
        assign sel_mask[i] = test_mode ? hit_group : hit_single;
    end

endmodule

// File: rtl/pam_cell_array.sv
module pam_cell_array #(
    parameter int NUM_BITS  = 8,
    parameter int NUM_WORDS = 8,
    localparam int WAW = $clog2(NUM_WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_stb,
    input  logic [WAW-1:0]      word_addr,
    input  logic [NUM_BITS-1:0] sel_mask,
    input  logic                din,
    output logic [NUM_BITS-1:0] row_out
);

    logic [NUM_BITS-1:0] rows [NUM_WORDS];
    logic [NUM_BITS-1:0] fill;

    assign fill = {NUM_BITS{din}};

    // Each word line updates only when it is the one addressed
    for (genvar r = 0; r < NUM_WORDS; r++) begin : g_row
        logic row_hit;
        assign row_hit = wr_stb && (word_addr == WAW'(r));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rows[r] <= '0;
            end else if (row_hit) begin
                rows[r] <= (rows[r] & ~sel_mask) | (fill & sel_mask);
            end
        end
    end

    assign row_out = rows[word_addr];

endmodule

// File: rtl/pam_group_compare.sv
module pam_group_compare #(
    parameter int NUM_BITS = 8
) (
    input  logic [NUM_BITS-1:0] row_in,
    input  logic [NUM_BITS-1:0] sel_mask,
    output logic                grp_same,
    output logic                low_bit
);

    logic [NUM_BITS-1:0] picked;
    logic                all_ones;
    logic                all_zeros;

    assign picked    = row_in & sel_mask;
    assign all_ones  = (picked == sel_mask);
    assign all_zeros = (picked == '0);
    assign grp_same  = all_ones || all_zeros;

    // Lowest-index selected line wins; the scan runs downwards so the last hit is the lowest
    always_comb begin
        low_bit = 1'b0;
        for (int i = NUM_BITS - 1; i >= 0; i--) begin
            if (sel_mask[i]) begin
                low_bit = row_in[i];
            end
        end
    end

endmodule

// File: rtl/pam_err_fsm.sv
module pam_err_fsm
    import pam_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    test_mode,
    input  access_e access,
    input  logic    grp_same,
    output logic    err
);

    err_state_e state_q;
    err_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ERR_CLAMPED;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        if (!test_mode) begin
            state_d = ERR_CLAMPED;
        end else begin
            unique case (access)
                ACC_WRITE: state_d = ERR_CLAMPED;
                ACC_READ:  state_d = grp_same ? ERR_PASS : ERR_FAIL;
                ACC_IDLE:  state_d = state_q;
                default:   state_d = state_q;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ERR_FAIL:    err = 1'b1;
            ERR_PASS:    err = 1'b0;
            ERR_CLAMPED: err = 1'b0;
            default:     err = 1'b0;
        endcase
    end

endmodule

// File: rtl/pam_array_top.sv
module pam_array_top
    import pam_pkg::*;
#(
    parameter int NUM_BITS   = 8,
    parameter int NUM_WORDS  = 8,
    parameter int NUM_GROUPS = 2,
    localparam int BAW = $clog2(NUM_BITS),
    localparam int WAW = $clog2(NUM_WORDS),
    localparam int GW  = $clog2(NUM_GROUPS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           test_mode,
    input  logic [GW-1:0]  grp_sel,
    input  logic [WAW-1:0] word_addr,
    input  logic [BAW-1:0] bit_addr,
    input  logic           rd_en,
    input  logic           wr_en,
    input  logic           din,
    output logic           dout,
    output logic           err
);

    access_e             access;
    logic [NUM_BITS-1:0] sel_mask;
    logic [NUM_BITS-1:0] row_data;
    logic                grp_same;
    logic                low_bit;
    logic                dout_q;

    // Write takes precedence over a read in the same cycle
    always_comb begin
        if (wr_en) begin
            access = ACC_WRITE;
        end else if (rd_en) begin
            access = ACC_READ;
        end else begin
            access = ACC_IDLE;
        end
    end

    pam_bit_decoder #(
        .NUM_BITS  (NUM_BITS),
        .NUM_GROUPS(NUM_GROUPS)
    ) dec_i (
        .test_mode(test_mode),
        .grp_sel  (grp_sel),
        .bit_addr (bit_addr),
        .sel_mask (sel_mask)
    );

    pam_cell_array #(
        .NUM_BITS (NUM_BITS),
        .NUM_WORDS(NUM_WORDS)
    ) cells_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (access == ACC_WRITE),
        .word_addr(word_addr),
        .sel_mask (sel_mask),
        .din      (din),
        .row_out  (row_data)
    );

    pam_group_compare #(
        .NUM_BITS(NUM_BITS)
    ) cmp_i (
        .row_in  (row_data),
        .sel_mask(sel_mask),
        .grp_same(grp_same),
        .low_bit (low_bit)
    );

    pam_err_fsm efsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .test_mode(test_mode),
        .access   (access),
        .grp_same (grp_same),
        .err      (err)
    );

    // Read data register, loaded only by an accepted read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= 1'b0;
        end else if (access == ACC_READ) begin
            dout_q <= low_bit;
        end
    end

    assign dout = dout_q;

endmodule

// File: rtl/pam_array_chk.sv
module pam_array_chk #(
    parameter int NUM_BITS   = 8,
    parameter int NUM_GROUPS = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                test_mode,
    input logic                rd_en,
    input logic                wr_en,
    input logic                dout,
    input logic                err,
    input logic [NUM_BITS-1:0] sel_mask,
    input logic                grp_same
);

    localparam int GROUP_SIZE = NUM_BITS / NUM_GROUPS;

    // R2: normal mode opens exactly one bit line
    p_single_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |-> ($countones(sel_mask) == 1));

    // R4: test mode opens one full group
    p_group_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> ($countones(sel_mask) == GROUP_SIZE));

    // R3: dout only moves on an accepted read
    p_dout_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && !wr_en) |=> $stable(dout));

    // R6: flag after a test read reflects the comparator
    p_read_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && rd_en && !wr_en) |=> (err == !$past(grp_same)));

    // R7: idle test cycles keep the flag
    p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && !rd_en && !wr_en) |=> $stable(err));

    // R8: writes clear the flag
    p_write_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !err);

    // R9: normal mode clears the flag
    p_normal_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |=> !err);

endmodule

bind pam_array_top pam_array_chk #(
    .NUM_BITS  (NUM_BITS),
    .NUM_GROUPS(NUM_GROUPS)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .test_mode(test_mode),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .dout     (dout),
    .err      (err),
    .sel_mask (sel_mask),
    .grp_same (grp_same)
);

// File: tb/pam_array_top_tb.sv
`timescale 1ns/1ps
module pam_array_top_tb_top;

    localparam int B   = 8;
    localparam int W   = 8;
    localparam int G   = 2;
    localparam int BAW = $clog2(B);
    localparam int WAW = $clog2(W);
    localparam int GW  = $clog2(G);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           test_mode = 1'b0;
    logic [GW-1:0]  grp_sel = '0;
    logic [WAW-1:0] word_addr = '0;
    logic [BAW-1:0] bit_addr = '0;
    logic           rd_en = 1'b0;
    logic           wr_en = 1'b0;
    logic           din = 1'b0;
    logic           dout;
    logic           err;

    always #2.5 clk = ~clk;

    pam_array_top #(
        .NUM_BITS(B), .NUM_WORDS(W), .NUM_GROUPS(G)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .grp_sel(grp_sel),
        .word_addr(word_addr), .bit_addr(bit_addr), .rd_en(rd_en),
        .wr_en(wr_en), .din(din), .dout(dout), .err(err)
    );

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    finished = 0;

    // Reference array and expected output state
    logic  model [W][B];
    logic  exp_dout = 1'b0;
    logic  exp_err  = 1'b0;

    // Scoreboard queues
    logic  q_dout [$];
    logic  q_err  [$];
    string q_tag  [$];

    task automatic check(input string tag, input logic act_d, input logic act_e,
                         input logic e_d, input logic e_e);
        n_checks++;
        if (act_d !== e_d || act_e !== e_e) begin
            n_fails++;
            $display("FAIL %s: dout=%b err=%b expected dout=%b err=%b at %0t",
                     tag, act_d, act_e, e_d, e_e, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    // One access per cycle; expectation pushed for the following edge
    task automatic drive(input logic tm, input int grp, input int wa, input int ba,
                         input logic rd, input logic wr, input logic d, input string tag);
        logic same;
        @(negedge clk);
        test_mode = tm;
        grp_sel   = GW'(grp);
        word_addr = WAW'(wa);
        bit_addr  = BAW'(ba);
        rd_en     = rd;
        wr_en     = wr;
        din       = d;
        if (wr) begin
            exp_err = 1'b0;
            if (tm) begin
                for (int i = 0; i < B; i++)
                    if (i % G == grp) model[wa][i] = d;
            end else begin
                model[wa][ba] = d;
            end
        end else if (!tm) begin
            exp_err = 1'b0;
            if (rd) exp_dout = model[wa][ba];
        end else if (rd) begin
            same = 1'b1;
            for (int i = 0; i < B; i++)
                if (i % G == grp && model[wa][i] != model[wa][grp]) same = 1'b0;
            exp_dout = model[wa][grp];
            exp_err  = !same;
        end
        q_dout.push_back(exp_dout);
        q_err.push_back(exp_err);
        q_tag.push_back(tag);
    endtask

    // Monitor: compare just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_tag.size() > 0) begin
                check(q_tag.pop_front(), dout, err, q_dout.pop_front(), q_err.pop_front());
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        for (int r = 0; r < W; r++)
            for (int c = 0; c < B; c++) model[r][c] = 1'b0;

        repeat (3) @(posedge clk);
        #1;
        check("R1 reset outputs", dout, err, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every cell reads back zero
        for (int r = 0; r < W; r++)
            for (int c = 0; c < B; c++)
                drive(0, 0, r, c, 1, 0, 0, "R1 cell zero");

        // R2 and R3: single-cell write and read back, neighbours untouched
        drive(0, 0, 2, 3, 0, 1, 1, "R2 write");
        drive(0, 0, 2, 3, 1, 0, 0, "R3 read written cell");
        drive(0, 0, 2, 2, 1, 0, 0, "R2 neighbour bit");
        drive(0, 0, 1, 3, 1, 0, 0, "R2 neighbour word");
        drive(0, 0, 2, 3, 1, 0, 0, "R3 read again");
        drive(0, 0, 0, 0, 0, 0, 0, "R3 hold on idle");

        // R4, R10: group write of ones, check group and non-members
        drive(1, 1, 5, 0, 0, 1, 1, "R4 group write");
        drive(1, 1, 5, 0, 1, 0, 0, "R10 all ones group");
        drive(1, 0, 5, 0, 1, 0, 0, "R10 all zeros group");
        for (int c = 0; c < B; c++)
            drive(0, 0, 5, c, 1, 0, 0, "R4 member check");
        drive(0, 0, 4, 1, 1, 0, 0, "R4 other word");
        drive(0, 0, 6, 7, 1, 0, 0, "R4 other word");

        // R6, R7: break the group and read in test mode
        drive(0, 0, 5, 5, 0, 1, 0, "R2 clear one member");
        drive(1, 1, 5, 0, 1, 0, 0, "R6 mismatch flagged");
        drive(1, 0, 0, 0, 0, 0, 0, "R7 hold");
        drive(1, 1, 7, 4, 0, 0, 0, "R7 hold");
        drive(1, 0, 5, 0, 1, 0, 0, "R6 agreeing group clears");
        drive(1, 1, 5, 0, 1, 0, 0, "R6 mismatch again");

        // R8: write clears the flag
        drive(1, 0, 0, 0, 0, 1, 0, "R8 write clears flag");
        drive(1, 1, 5, 0, 1, 0, 0, "R6 mismatch third");
        // R9: normal-mode idle clears the flag
        drive(0, 0, 0, 0, 0, 0, 0, "R9 normal mode clears flag");

        // R5: lowest member differs from the rest
        drive(0, 0, 3, 0, 0, 1, 1, "R2 set lowest member");
        drive(1, 0, 3, 0, 1, 0, 0, "R5 lowest member value");
        drive(1, 1, 3, 0, 1, 0, 0, "R5 other group");

        // R8: simultaneous read and write, read ignored
        drive(1, 1, 5, 0, 1, 0, 0, "R6 set flag before overlap");
        drive(1, 0, 3, 0, 1, 1, 0, "R8 write wins over read");
        drive(1, 0, 3, 0, 1, 0, 0, "R4 overlap write landed");

        // R10: flip a whole group and confirm only dout shows it
        drive(1, 1, 6, 0, 0, 1, 1, "R4 fill group");
        drive(1, 1, 6, 0, 1, 0, 0, "R10 polarity one");
        drive(1, 1, 6, 0, 0, 1, 0, "R4 flip group");
        drive(1, 1, 6, 0, 1, 0, 0, "R10 polarity zero");

        // Mixed traffic against the reference model
        for (int k = 0; k < 600; k++) begin
            int sel;
            sel = int'($urandom_range(0, 9));
            case (sel)
                0, 1: drive(0, 0, int'($urandom_range(0, W-1)), int'($urandom_range(0, B-1)),
                            0, 1, 1'($urandom_range(0, 1)), "R2 mixed write");
                2, 3: drive(0, 0, int'($urandom_range(0, W-1)), int'($urandom_range(0, B-1)),
                            1, 0, 0, "R3 mixed read");
                4:    drive(1, int'($urandom_range(0, G-1)), int'($urandom_range(0, W-1)), 0,
                            0, 1, 1'($urandom_range(0, 1)), "R4 mixed group write");
                5, 6: drive(1, int'($urandom_range(0, G-1)), int'($urandom_range(0, W-1)), 0,
                            1, 0, 0, "R6 mixed group read");
                7:    drive(1, 0, 0, 0, 0, 0, 0, "R7 mixed hold");
                8:    drive(1, int'($urandom_range(0, G-1)), int'($urandom_range(0, W-1)), 0,
                            1, 1, 1'($urandom_range(0, 1)), "R8 mixed overlap");
                default: drive(0, 0, 0, 0, 0, 0, 0, "R9 mixed normal idle");
            endcase
        end

        @(negedge clk);
        rd_en = 1'b0;
        wr_en = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        finish_run();
    end

endmodule